// File: doc/BRIEF.md
# Twelve-Hour Time-of-Day Counter

This block keeps time of day as three binary registers: seconds, minutes and hours. A divider inside the block counts system-clock cycles and produces a one-cycle enable once per second (100,000,000 cycles at a 100 MHz clock by default). Each enable advances the seconds register. A seconds rollover advances the minutes register, and a minutes rollover advances the hours register. The hours register covers 0 to 12.

Two single-cycle pulse inputs let the user set the time by hand, one for minutes and one for hours. A hand-set minute that passes 59 returns to 0 and does not touch the hour. Only a rollover caused by time passing carries into the next register. The three registers drive the outputs directly, in binary, for a display or alarm-compare stage further down the chip.

Top module: `hms_counter`

## Requirements
- R1: While `rst` is high at a rising edge, `sec`, `min`, `hour` and the internal cycle divider are all cleared to 0.
- R2: After reset is released, the internal one-second enable is high for exactly one cycle in every `TICK_PERIOD` cycles. The first enable falls in the `TICK_PERIOD`-th cycle after release, and `sec` changes on the rising edge that ends that cycle.
- R3: `sec` holds its value on every edge without the enable. It steps by one on an edge with the enable, going from 59 back to 0, and never exceeds 59.
- R4: When `sec` goes from 59 to 0, `min` advances by one on the same edge.
- R5: When `min` goes from 59 to 0 because `sec` rolled over, `hour` advances by one on the same edge.
- R6: A one-cycle high on `min_bump` advances `min` by one on that edge. From 59 it goes to 0 and leaves `hour` unchanged (1:59 becomes 1:00).
- R7: A one-cycle high on `hour_bump` advances `hour` by one on that edge, going from 12 to 0. A natural carry also takes the hour from 12 to 0.
- R8: When a manual pulse and a carry reach the same register on the same edge, that register advances by one only.
- R9: `hour` never exceeds 12, and `min` never exceeds 59.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| min_bump | input | 1 | One-cycle pulse: add one minute by hand |
| hour_bump | input | 1 | One-cycle pulse: add one hour by hand |
| sec | output | 6 | Seconds, binary 0..59 |
| min | output | 6 | Minutes, binary 0..59 |
| hour | output | 4 | Hours, binary 0..12 |

## Verification
The assertions assume that both bump inputs are clean synchronous pulses: each stays high for at most one cycle per press, is free of glitches, and is already in the `clk` domain. The properties about step size depend on this. The bench drives every bump for exactly one cycle, just after a falling edge, and returns it low before the next cycle. It also uses a short `TICK_PERIOD` so that carries across minutes and hours occur within a few thousand cycles. Bump pulses are placed both away from and exactly on enable cycles that roll over seconds or minutes, which exercises the coincident-advance rule.

// File: rtl/hms_pkg.sv
package hms_pkg;
   // Bits needed to hold 0..maxv inclusive.
   function automatic int bits_for(input int maxv);
      return (maxv < 1) ? 1 : $clog2(maxv + 1);
   endfunction
endpackage

// File: rtl/tick_divider.sv
module tick_divider #(
   parameter int TICK_PERIOD = 100_000_000
) (
   input  logic clk,
   input  logic rst,
   output logic tick
);
   localparam int CW = (TICK_PERIOD > 1) ? $clog2(TICK_PERIOD) : 1;

   if (TICK_PERIOD < 1) begin : g_bad_period
      $error("tick_divider: TICK_PERIOD must be at least 1");
   end

   if (TICK_PERIOD == 1) begin : g_every_cycle
      assign tick = 1'b1;
   end else begin : g_count
      localparam logic [CW-1:0] LAST = CW'(TICK_PERIOD - 1);
      logic [CW-1:0] cyc_q;

      assign tick = (cyc_q == LAST);

      always_ff @(posedge clk) begin
         if (rst)       cyc_q <= '0;
         else if (tick) cyc_q <= '0;
         else           cyc_q <= cyc_q + 1'b1;
      end
   end
endmodule

// File: rtl/wrap_counter.sv
module wrap_counter #(
   parameter int MAXV = 59,
   parameter int W    = hms_pkg::bits_for(MAXV)
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         adv,    // natural carry from the stage below
   input  logic         bump,   // manual increment pulse
   output logic [W-1:0] value,
   output logic         wrap    // natural rollover only
);
   localparam logic [W-1:0] TOP = W'(MAXV);

   if (W < hms_pkg::bits_for(MAXV)) begin : g_bad_width
      $error("wrap_counter: W too narrow for MAXV");
   end
   if (MAXV < 1) begin : g_bad_max
      $error("wrap_counter: MAXV must be at least 1");
   end

   logic at_top;
   logic step;

   assign at_top = (value == TOP);
   assign step   = adv | bump;        // coincident requests merge into one step
   assign wrap   = adv & at_top;

   always_ff @(posedge clk) begin
      if (rst)         value <= '0;
      else if (step)   value <= at_top ? '0 : value + 1'b1;
   end
endmodule

// File: rtl/hms_counter.sv
module hms_counter #(
   parameter int TICK_PERIOD = 100_000_000,
   parameter int SEC_LAST    = 59,
   parameter int MIN_LAST    = 59,
   parameter int HOUR_LAST   = 12,
   parameter int SEC_W       = hms_pkg::bits_for(SEC_LAST),
   parameter int MIN_W       = hms_pkg::bits_for(MIN_LAST),
   parameter int HOUR_W      = hms_pkg::bits_for(HOUR_LAST)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              min_bump,
   input  logic              hour_bump,
   output logic [SEC_W-1:0]  sec,
   output logic [MIN_W-1:0]  min,
   output logic [HOUR_W-1:0] hour
);
   logic sec_tick;
   logic sec_wrap;
   logic min_wrap;
   logic hour_wrap_unused;

   tick_divider #(.TICK_PERIOD(TICK_PERIOD)) u_div (
      .clk  (clk),
      .rst  (rst),
      .tick (sec_tick)
   );

   wrap_counter #(.MAXV(SEC_LAST), .W(SEC_W)) u_sec (
      .clk   (clk),
      .rst   (rst),
      .adv   (sec_tick),
      .bump  (1'b0),
      .value (sec),
      .wrap  (sec_wrap)
   );

   wrap_counter #(.MAXV(MIN_LAST), .W(MIN_W)) u_min (
      .clk   (clk),
      .rst   (rst),
      .adv   (sec_wrap),
      .bump  (min_bump),
      .value (min),
      .wrap  (min_wrap)
   );

   wrap_counter #(.MAXV(HOUR_LAST), .W(HOUR_W)) u_hour (
      .clk   (clk),
      .rst   (rst),
      .adv   (min_wrap),
      .bump  (hour_bump),
      .value (hour),
      .wrap  (hour_wrap_unused)
   );
endmodule

// File: rtl/hms_counter_chk.sv
module hms_counter_chk #(
   parameter int TICK_PERIOD = 100_000_000,
   parameter int SEC_LAST    = 59,
   parameter int MIN_LAST    = 59,
   parameter int HOUR_LAST   = 12,
   parameter int SEC_W       = 6,
   parameter int MIN_W       = 6,
   parameter int HOUR_W      = 4
) (
   input logic              clk,
   input logic              rst,
   input logic              min_bump,
   input logic              hour_bump,
   input logic [SEC_W-1:0]  sec,
   input logic [MIN_W-1:0]  min,
   input logic [HOUR_W-1:0] hour,
   input logic              tick
);
   int unsigned gap;
   logic sec_roll, min_roll;

   assign sec_roll = tick && (sec == SEC_W'(SEC_LAST));
   assign min_roll = sec_roll && (min == MIN_W'(MIN_LAST));

   always_ff @(posedge clk) begin
      if (rst || tick) gap <= 0;
      else             gap <= gap + 1;
   end

   AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (sec == '0 && min == '0 && hour == '0)); // R1
   AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst) tick |-> (gap == TICK_PERIOD - 1)); // R2
   AST_SEC_HOLD: assert property (@(posedge clk) disable iff (rst) !tick |=> $stable(sec)); // R3
   AST_SEC_RANGE: assert property (@(posedge clk) disable iff (rst) sec <= SEC_W'(SEC_LAST)); // R3
   AST_MIN_CARRY: assert property (@(posedge clk) disable iff (rst) (sec_roll && min != MIN_W'(MIN_LAST)) |=> (min == $past(min) + 1'b1)); // R4
   AST_HOUR_CARRY: assert property (@(posedge clk) disable iff (rst) (min_roll && hour != HOUR_W'(HOUR_LAST)) |=> (hour == $past(hour) + 1'b1)); // R5
   AST_MIN_BUMP_NO_CARRY: assert property (@(posedge clk) disable iff (rst) (min_bump && !sec_roll && !hour_bump) |=> $stable(hour)); // R6
   AST_HOUR_WRAP: assert property (@(posedge clk) disable iff (rst) (hour_bump && hour == HOUR_W'(HOUR_LAST)) |=> (hour == '0)); // R7
   AST_MIN_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst) (min_bump || sec_roll) |=> (min == (($past(min) == MIN_W'(MIN_LAST)) ? '0 : $past(min) + 1'b1))); // R8
   AST_MIN_IDLE: assert property (@(posedge clk) disable iff (rst) !(min_bump || sec_roll) |=> $stable(min)); // R8
   AST_HOUR_RANGE: assert property (@(posedge clk) disable iff (rst) (hour <= HOUR_W'(HOUR_LAST) && min <= MIN_W'(MIN_LAST))); // R9
endmodule

bind hms_counter hms_counter_chk #(
   .TICK_PERIOD (TICK_PERIOD),
   .SEC_LAST    (SEC_LAST),
   .MIN_LAST    (MIN_LAST),
   .HOUR_LAST   (HOUR_LAST),
   .SEC_W       (SEC_W),
   .MIN_W       (MIN_W),
   .HOUR_W      (HOUR_W)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .min_bump  (min_bump),
   .hour_bump (hour_bump),
   .sec       (sec),
   .min       (min),
   .hour      (hour),
   .tick      (sec_tick)
);

// File: tb/hms_counter_test.sv
module hms_counter_test;
   localparam int P = 5;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic min_bump = 1'b0;
   logic hour_bump = 1'b0;
   logic [5:0] sec;
   logic [5:0] min;
   logic [3:0] hour;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // reference model state
   int mcnt = 0, msec = 0, mmin = 0, mhr = 0;

   always #4 clk = ~clk;   // 125 MHz

   hms_counter #(.TICK_PERIOD(P)) uut (
      .clk       (clk),
      .rst       (rst),
      .min_bump  (min_bump),
      .hour_bump (hour_bump),
      .sec       (sec),
      .min       (min),
      .hour      (hour)
   );

   task automatic compare(input string tag);
      checks++;
      if (int'(sec) != msec || int'(min) != mmin || int'(hour) != mhr) begin
         fails++;
         $display("FAIL %s: got %0d:%0d:%0d expected %0d:%0d:%0d",
                  tag, hour, min, sec, mhr, mmin, msec);
      end
      checks++;
      if (int'(hour) > 12 || int'(min) > 59 || int'(sec) > 59) begin
         fails++;
         $display("FAIL R9: got %0d:%0d:%0d expected all in range", hour, min, sec);
      end
   endtask

   // Called just after a falling edge; one full clock cycle.
   task automatic cyc(input logic m, input logic h, input string tag);
      bit tk, sw, mw;
      min_bump  = m;
      hour_bump = h;
      tk   = (mcnt == P - 1);
      mcnt = tk ? 0 : mcnt + 1;
      sw   = tk && (msec == 59);
      if (tk) msec = (msec == 59) ? 0 : msec + 1;
      mw   = sw && (mmin == 59);
      if (sw || m) mmin = (mmin == 59) ? 0 : mmin + 1;
      if (mw || h) mhr  = (mhr == 12) ? 0 : mhr + 1;
      @(negedge clk);
      compare(tag);
      min_bump  = 1'b0;
      hour_bump = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      compare("R1");                        // reset state
      rst = 1'b0;

      // R2 R3 R4: free running past a minute boundary
      for (int i = 0; i < 2 * P - 1; i++) cyc(0, 0, "R2");
      for (int i = 0; i < 70 * P; i++) cyc(0, 0, "R4");

      // R6: hand-set minutes through 59 -> 0, hour held
      while (mmin != 59) cyc(1, 0, "R6");
      cyc(1, 0, "R6");
      for (int i = 0; i < 3; i++) cyc(0, 0, "R6");

      // R7: hand-set hours through 12 -> 0, then back to 12
      for (int i = 0; i < 13; i++) cyc(0, 1, "R7");
      while (mhr != 12) cyc(0, 1, "R7");

      // R5 R7: natural carry 12:59:59 -> 0:00:00
      while (mmin != 59) cyc(1, 0, "R6");
      for (int i = 0; i < 61 * P; i++) cyc(0, 0, "R5");

      // R8: minute bump coincides with a seconds rollover
      while (!(mcnt == P - 1 && msec == 59)) cyc(0, 0, "R3");
      cyc(1, 0, "R8");

      // R8: hour bump coincides with a natural minute rollover
      while (mmin != 59) cyc(1, 0, "R6");
      while (!(mcnt == P - 1 && msec == 59)) cyc(0, 0, "R3");
      cyc(0, 1, "R8");
      for (int i = 0; i < 2 * P; i++) cyc(0, 0, "R3");

      // R1: reset mid-count clears everything
      rst = 1'b1;
      @(negedge clk);
      @(negedge clk);
      mcnt = 0; msec = 0; mmin = 0; mhr = 0;
      compare("R1");
      rst = 1'b0;
      for (int i = 0; i < 3 * P; i++) cyc(0, 0, "R2");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule